// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block streams a rectangular region of an SDRAM bank out through a valid/data port, one burst at a time. Software or an upstream engine pulses `start` with a first row, a row count and a bank. The block then raises `rd_req` to an external arbiter and waits for `rd_grant`. Once granted, it opens the row and waits the activate-to-column delay. It then issues one READ per burst, walking the burst index across the row. Data returns on `dq_in` after the CAS latency and is forwarded on `rd_data` with `rd_valid`.

A row ends after its last burst. At that point the block lets the outstanding data arrive, precharges all banks, waits the precharge time and asks the arbiter again before it opens the next row. If a refresh is pending when a burst boundary comes, the block stops in the same way. It keeps its row and burst position, so the next grant reopens the same row and continues with the next unread burst. After the last row of the region has been precharged, `done` pulses once and the block stays silent until the next `start`.

Top module: `sdram_burst_reader`

## Requirements
- R1: After reset `cmd` is NOP (4'b0111), and `rd_req`, `rd_valid` and `done` are low. `rd_req` stays low, even while `rd_grant` is high, until a `start` pulse arrives in the idle state.
- R2: `cmd` is {cs_n, ras_n, cas_n, we_n} and only ever carries ACTIVE 4'b0011, READ 4'b0101, PRECHARGE 4'b0010 or NOP 4'b0111. Every cycle that carries no command shows NOP with `addr` and `bank` at zero.
- R3: If `rd_grant` is sampled high with `rd_req` high and `refresh_pending` low, the next cycle carries ACTIVE with the current row on `addr` and the region bank on `bank`. The first READ comes exactly T_RCD cycles after that ACTIVE.
- R4: Inside an open row, READs come every BURST_LEN cycles. `addr` is the burst index shifted left by log2(BURST_LEN), which is a shift of 2 for the default length 4, and `bank` is the region bank.
- R5: Suppose cycle c carries a READ. Then the dq_in words present in cycles c+CAS_LAT to c+CAS_LAT+BURST_LEN-1 appear on `rd_data`, with `rd_valid` high exactly in cycles c+CAS_LAT+1 to c+CAS_LAT+BURST_LEN.
- R6: After the last burst of a row no further READ is issued. A PRECHARGE with addr bit 10 set (all banks) and bank 0 follows BURST_LEN+CAS_LAT+1 cycles after the last READ, once every beat has been delivered.
- R7: T_RP cycles after that PRECHARGE, `rd_req` rises again if rows remain. `rd_req` is high only while the block waits for a grant, and the next grant opens the following row (modulo 2^ADDR_W) starting at burst 0.
- R8: If `refresh_pending` is high at a burst boundary, meaning the cycle in which the next READ of the row would be issued, no READ is issued and the block drains and precharges as in R6. The next grant reopens the same row and resumes at the next unread burst.
- R9: `done` is high for exactly one cycle, T_RP cycles after the PRECHARGE that closes the last row of the region (first_row .. first_row+row_count-1). From then on `rd_req` stays low until the next `start`.
- R10: A `start` pulse while a region is in progress is ignored. First row, row count and bank are latched only at an accepted `start`.
- R11: `rd_grant` has no effect while `rd_req` is low or `refresh_pending` is high: no ACTIVE follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a region (accepted only when idle) |
| first_row | input | ADDR_W | First row of the region |
| row_count | input | ADDR_W | Number of rows in the region (1 or more) |
| region_bank | input | BANK_W | Bank read for the whole region |
| rd_req | output | 1 | Request to the arbiter |
| rd_grant | input | 1 | Grant from the arbiter |
| refresh_pending | input | 1 | A refresh is waiting for the bus |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| addr | output | ADDR_W | Row / column / precharge address |
| bank | output | BANK_W | Bank address |
| dq_in | input | DQ_W | SDRAM data bus, read direction |
| rd_valid | output | 1 | Beat on rd_data is valid |
| rd_data | output | DQ_W | Returned read word |
| done | output | 1 | One-cycle pulse at the end of the region |

## Verification
The bench targets the region start at the top row, where the row counter must wrap to 0; a design that carried into a wider count would request the wrong row and return mismatched words. It also puts refresh windows over burst boundaries. A sequencer that sampled the refresh too early would cut a burst short and lose beats. One that forgot its column position would read burst 0 again after the preemption, which shows up as wrong data or a wrong column address. Grants that arrive during a refresh or while the block is busy, and a second start in mid-region, check that no stray ACTIVE appears and that the latched region is not replaced. The precharge cycle is checked against the last data beat, so a precharge issued before the pipeline drains is caught.

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader #(
  parameter int ADDR_W         = 12,
  parameter int BANK_W         = 2,
  parameter int DQ_W           = 16,
  parameter int BURST_LEN      = 4,
  parameter int CAS_LAT        = 3,
  parameter int T_RCD          = 3,
  parameter int T_RP           = 2,
  parameter int BURSTS_PER_ROW = 128
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_row,
  input  logic [ADDR_W-1:0] row_count,
  input  logic [BANK_W-1:0] region_bank,
  output logic              rd_req,
  input  logic              rd_grant,
  input  logic              refresh_pending,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              done
);
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam int BL_SH = $clog2(BURST_LEN);
  localparam int COL_W = (BURSTS_PER_ROW > 1) ? $clog2(BURSTS_PER_ROW) : 1;
  localparam int M1 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M2 = (BURST_LEN > CAS_LAT + 1) ? BURST_LEN : CAS_LAT + 1;
  localparam int TW = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam int BW = $clog2(BURST_LEN) + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_OPEN, S_READ, S_DRAIN, S_PREW} st_t;

  st_t               st;
  logic [TW-1:0]     wcnt;
  logic [ADDR_W-1:0] row, rows_left;
  logic [COL_W-1:0]  col;
  logic [BANK_W-1:0] bsel;
  logic [CAS_LAT:0]  issue_sr;
  logic [BW-1:0]     beats;

  wire tz       = (wcnt == '0);
  wire last_col = (col == COL_W'(BURSTS_PER_ROW - 1));
  wire fire_rd  = (st == S_OPEN && tz) ||
                  (st == S_READ && tz && col != '0 && !refresh_pending);

  assign rd_req = (st == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wcnt <= '0; row <= '0; rows_left <= '0; col <= '0; bsel <= '0;
      cmd <= C_NOP; addr <= '0; bank <= '0; done <= 1'b0;
    end else begin
      cmd <= C_NOP; addr <= '0; bank <= '0; done <= 1'b0;
      if (!tz) wcnt <= wcnt - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          row <= first_row; rows_left <= row_count; col <= '0; bsel <= region_bank;
          st <= S_WAIT;
        end
        S_WAIT: if (rd_grant && !refresh_pending) begin
          cmd <= C_ACT; addr <= row; bank <= bsel;
          wcnt <= TW'(T_RCD - 1); st <= S_OPEN;
        end
        S_OPEN: ;
        S_READ: if (tz && !fire_rd) begin
          st <= S_DRAIN; wcnt <= TW'(CAS_LAT);
        end
        S_DRAIN: if (tz) begin
          cmd <= C_PRE; addr <= '0; addr[10] <= 1'b1;
          wcnt <= TW'(T_RP - 1); st <= S_PREW;
        end
        S_PREW: if (tz) begin
          if (rows_left == '0) begin
            done <= 1'b1; st <= S_IDLE;
          end else st <= S_WAIT;
        end
        default: st <= S_IDLE;
      endcase
      if (fire_rd) begin
        cmd <= C_RD; addr <= ADDR_W'(col) << BL_SH; bank <= bsel;
        wcnt <= TW'(BURST_LEN - 1); st <= S_READ;
        if (last_col) begin
          col <= '0; row <= row + ADDR_W'(1); rows_left <= rows_left - ADDR_W'(1);
        end else col <= col + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_sr <= '0; beats <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      issue_sr <= {issue_sr[CAS_LAT-1:0], fire_rd};
      if (issue_sr[CAS_LAT]) begin
        rd_valid <= 1'b1; rd_data <= dq_in; beats <= BW'(BURST_LEN - 1);
      end else if (beats != '0) begin
        rd_valid <= 1'b1; rd_data <= dq_in; beats <= beats - 1'b1;
      end else rd_valid <= 1'b0;
    end
  end
endmodule

module sdram_burst_reader_chk #(
  parameter int BURST_LEN = 4
)(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       rd_req,
  input logic       rd_grant,
  input logic       refresh_pending,
  input logic       rd_valid,
  input logic       done
);
  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0011 || cmd == 4'b0101 || cmd == 4'b0010 || cmd == 4'b0111);
  p_act_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0011 |=> (cmd != 4'b0011 && cmd != 4'b0010));
  p_read_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (BURST_LEN > 1 && cmd == 4'b0101) |=> cmd == 4'b0111);
  p_pre_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> !rd_valid);
  p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> cmd == 4'b0111);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
  p_grant_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_grant && refresh_pending) |=> cmd == 4'b0111);
endmodule

bind sdram_burst_reader sdram_burst_reader_chk #(.BURST_LEN(BURST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .rd_req(rd_req), .rd_grant(rd_grant),
  .refresh_pending(refresh_pending), .rd_valid(rd_valid), .done(done)
);

// File: tb/tb_sdram_burst_reader.sv
module tb_sdram_burst_reader;
  localparam int AW = 12, BKW = 2, DW = 16;
  localparam int BL = 4, CL = 3, TRCD = 3, TRP = 2, BPR = 4;
  localparam int NROWS = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic start = 0, rd_grant = 0, refresh_pending = 0;
  logic [AW-1:0] first_row = '0, row_count = '0;
  logic [BKW-1:0] region_bank = '0;
  logic [DW-1:0] dq_in = '0;
  logic rd_req, rd_valid, done;
  logic [3:0] cmd;
  logic [AW-1:0] addr;
  logic [BKW-1:0] bank;
  logic [DW-1:0] rd_data;

  always #5 clk = ~clk;

  sdram_burst_reader #(.ADDR_W(AW), .BANK_W(BKW), .DQ_W(DW), .BURST_LEN(BL),
    .CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .BURSTS_PER_ROW(BPR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_row(first_row),
    .row_count(row_count), .region_bank(region_bank), .rd_req(rd_req),
    .rd_grant(rd_grant), .refresh_pending(refresh_pending), .cmd(cmd),
    .addr(addr), .bank(bank), .dq_in(dq_in), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done));

  int n_chk = 0, n_bad = 0;
  int edge_n = 0;
  bit run = 0, refr_auto = 0, refr_force = 0;
  int pre_cnt = 0, act_cnt = 0, done_cnt = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, edge_n);
    end
  endtask

  function automatic logic [DW-1:0] word(int b, int r, int c);
    return DW'(r * 37 + c * 11 + b * 4099 + 'h1234);
  endfunction

  // reference model, stepped on each rising edge from the stimulus
  int ph = 0, t = 0, m_row = 0, m_left = 0, m_burst = 0, m_bank = 0;
  bit m_end = 0;
  logic [3:0] e_cmd = 4'b0111;
  int e_addr = 0, e_bank = 0;
  bit e_done = 0;
  string e_tag = "";
  logic [DW-1:0] exp_beat [int];

  task automatic m_issue();
    e_cmd = 4'b0101; e_addr = m_burst * BL; e_bank = m_bank;
    for (int j = 0; j < BL; j++)
      exp_beat[edge_n + CL + 1 + j] = word(m_bank, m_row, m_burst * BL + j);
    m_burst++;
    m_end = (m_burst == BPR);
    if (m_end) begin
      m_burst = 0; m_row = (m_row + 1) % NROWS; m_left--;
    end
    ph = 3; t = BL;
  endtask

  always @(posedge clk) begin
    int ph0;
    edge_n++;
    if (!rst_n) begin
      ph = 0; t = 0; e_cmd = 4'b0111; e_addr = 0; e_bank = 0; e_done = 0; e_tag = "";
      exp_beat.delete();
    end else begin
      ph0 = ph;
      e_cmd = 4'b0111; e_addr = 0; e_bank = 0; e_done = 0; e_tag = "";
      case (ph)
        0: if (start) begin
          m_row = first_row; m_left = row_count; m_burst = 0; m_bank = region_bank; ph = 1;
        end
        1: if (rd_grant && !refresh_pending) begin
          e_cmd = 4'b0011; e_addr = m_row; e_bank = m_bank; ph = 2; t = TRCD;
        end else if (rd_grant) e_tag = "R11";
        2: begin t--; if (t == 0) m_issue(); end
        3: begin
          t--;
          if (t == 0) begin
            if (m_end || refresh_pending) begin
              if (!m_end) e_tag = "R8";
              ph = 4; t = CL + 1;
            end else m_issue();
          end
        end
        4: begin t--; if (t == 0) begin e_cmd = 4'b0010; e_addr = 1024; ph = 5; t = TRP; end end
        5: begin
          t--;
          if (t == 0) begin
            if (m_left == 0) begin e_done = 1; ph = 0; end else ph = 1;
          end
        end
        default: ph = 0;
      endcase
      if (start && ph0 != 0) e_tag = "R10";
    end
  end

  // comparison, memory model and refresh stimulus, all away from the rising edge
  int mem_row = 0;
  logic [DW-1:0] dq_sched [int];
  always @(negedge clk) begin
    string tg;
    if (run) begin
      tg = (e_tag != "") ? e_tag : (e_cmd == 4'b0011) ? "R3" : (e_cmd == 4'b0101) ? "R4" :
           (e_cmd == 4'b0010) ? "R6" : "R2";
      check(cmd === e_cmd, tg, "cmd", cmd, e_cmd);
      check(addr === AW'(e_addr) && bank === BKW'(e_bank), tg, "addr/bank",
            {bank, addr}, {BKW'(e_bank), AW'(e_addr)});
      check(rd_req === (ph == 1), (e_tag == "R10") ? "R10" : "R7", "rd_req", rd_req, ph == 1);
      check(rd_valid === exp_beat.exists(edge_n), "R5", "rd_valid", rd_valid, exp_beat.exists(edge_n));
      if (exp_beat.exists(edge_n)) begin
        check(rd_data === exp_beat[edge_n], "R5", "rd_data", rd_data, exp_beat[edge_n]);
        exp_beat.delete(edge_n);
      end
      check(done === e_done, "R9", "done", done, e_done);
      if (e_done) done_cnt++;
      if (cmd == 4'b0010) pre_cnt++;
      if (cmd == 4'b0011) act_cnt++;
    end
    if (cmd == 4'b0011) mem_row = addr;
    if (cmd == 4'b0101)
      for (int j = 0; j < BL; j++) dq_sched[edge_n + CL + j] = word(bank, mem_row, addr + j);
    if (dq_sched.exists(edge_n)) begin
      dq_in <= dq_sched[edge_n]; dq_sched.delete(edge_n);
    end else dq_in <= DW'(16'hA5C3 ^ edge_n);
    refresh_pending <= refr_force | (refr_auto && (edge_n % 19) < 3);
  end

  task automatic start_region(int fr, int rc, int bk);
    @(negedge clk);
    start = 1; first_row = AW'(fr); row_count = AW'(rc); region_bank = BKW'(bk);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int d0 = done_cnt;
    for (int n = 0; n < 3000 && done_cnt == d0; n++) @(negedge clk);
    check(done_cnt == d0 + 1, "R9", "region completes", done_cnt, d0 + 1);
  endtask

  initial begin
    int a0, p0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    run = 1;
    @(negedge clk);
    check(cmd === 4'b0111, "R1", "reset cmd", cmd, 4'b0111);
    check(rd_req === 0 && rd_valid === 0 && done === 0, "R1", "reset flags",
          {rd_req, rd_valid, done}, 0);
    rd_grant = 1;
    repeat (10) @(negedge clk);
    check(rd_req === 0, "R1", "no request before start", rd_req, 0);

    // plain two-row region, grant always offered
    start_region(5, 2, 1);
    wait_done();
    repeat (4) @(negedge clk);
    check(rd_req === 0, "R9", "quiet after done", rd_req, 0);

    // region across the top row, late grant, refresh windows, spurious start
    rd_grant = 0;
    p0 = pre_cnt;
    start_region(NROWS - 2, 3, 2);
    repeat (6) @(negedge clk);
    check(rd_req === 1, "R7", "request held without grant", rd_req, 1);
    rd_grant = 1; refr_auto = 1;
    repeat (20) @(negedge clk);
    start_region(100, 1, 0);
    wait_done();
    refr_auto = 0;
    check(pre_cnt - p0 > 3, "R8", "refresh preemptions occurred", pre_cnt - p0, 4);

    // grant offered while refresh is pending
    refr_force = 1;
    a0 = act_cnt;
    start_region(77, 1, 3);
    repeat (30) @(negedge clk);
    check(act_cnt == a0, "R11", "no ACTIVE under refresh", act_cnt - a0, 0);
    refr_force = 0;
    wait_done();

    check(done_cnt == 3, "R9", "done pulses", done_cnt, 3);
    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    if (edge_n > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", edge_n, 100000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule